// File: doc/BRIEF.md
# Paired-Byte Word-Write Bus Interface

This block sits between a CPU that issues byte-wide table writes and an external 16-bit memory reached over a multiplexed address/data bus. The CPU gives a 21-bit byte pointer, a data byte and a one-clock start strobe. The block then runs one fixed bus cycle: an address phase with an address latch pulse, a data phase with the write strobe, and a release phase. It reports progress with a busy level and a one-clock done pulse.

Bytes are joined into words in pairs. A write to an even byte address only parks the byte in a holding register. During that cycle's data phase the bus is left undriven and no strobe is given. The next write, to the odd byte address of the same word, puts the new byte on the upper half of the bus and the parked byte on the lower half. The high write strobe then writes the whole word at once.

The external word address is pointer bits 20:1. A configuration input chooses whether 12, 16 or 20 of those bits reach the pins.

Top module: `word_write_bus_if`

## Requirements
- R1: After reset, busy and done are 0. ALE and the bus output enable are 0. Chip enable, output enable, both write strobes and both byte selects (all active low) are 1. The holding register is 0x00.
- R2: When a start is accepted in idle, the next cycle is the address phase. In that phase ALE is 1, the bus is driven, and the bus carries word-address bits 15:0, where the word address is pointer bits 20:1. The upper address pins carry word-address bits 19:16. ALE is high for exactly one cycle.
- R3: The width setting is 0 for 12 bits, 1 for 16 bits, and 2 or 3 for 20 bits. Word-address bits at or above the chosen width are driven low. The setting is taken when the start is accepted. The upper address pins are low while idle.
- R4: Pointer bit 0 = 0 marks an even write. For an even write, the data and release phases leave the bus undriven (output enable 0) and the high write strobe stays 1. The data byte is stored in the holding register.
- R5: Pointer bit 0 = 1 marks an odd write. For an odd write, the high write strobe is 0 for exactly the two data-phase cycles. The bus is driven with the new byte on bits 15:8 and the holding register on bits 7:0.
- R6: The low write strobe and the output enable pin stay 1 at all times.
- R7: Both byte selects are 0 for every cycle of every bus access, even or odd. The byte-address pin shows pointer bit 0 during the access and is 0 in idle.
- R8: Chip enable is 0 for exactly four cycles per access. In the release cycle the high write strobe is back at 1, and for an odd write the data is still driven.
- R9: Busy is 1 from the cycle after the accepted start through the release cycle. Done is 1 for the single cycle after release, with busy back at 0. A start while busy is ignored.
- R10: An odd write that has no even write before it combines whatever the holding register holds. The holding register is overwritten by each even write and by nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_aw | input | 2 | Address width select: 0=12, 1=16, 2/3=20 bits |
| req_start | input | 1 | One-clock write request |
| req_ptr | input | 21 | Byte pointer of the write |
| req_data | input | 8 | Data byte of the write |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| ext_addr_hi | output | 4 | Upper word-address pins (bits 19:16) |
| ext_ad_o | output | 16 | Multiplexed address/data bus value |
| ext_ad_oe | output | 1 | Bus output enable (0 = high impedance) |
| ext_ale | output | 1 | Address latch enable |
| ext_ce_n | output | 1 | Chip enable, active low |
| ext_oe_n | output | 1 | Output enable, active low |
| ext_wrh_n | output | 1 | High write strobe, active low |
| ext_wrl_n | output | 1 | Low write strobe, active low |
| ext_ub_n | output | 1 | Upper byte select, active low |
| ext_lb_n | output | 1 | Lower byte select, active low |
| ext_ba0 | output | 1 | Byte-address bit |

## Verification
The assertions take for granted that req_ptr, req_data and cfg_aw are valid in any cycle where req_start is high. They also assume start pulses last one clock, so that one accepted start gives exactly one ALE pulse and one strobe pair. The stimulus keeps to this: it drives a single start pulse on a falling edge and holds the request fields steady in that cycle. A few extra starts are issued in the middle of a cycle on purpose, to show they are ignored. Random pointers, data and width settings are mixed with even/odd pairs on the same word, lone odd writes, and the largest address.

// File: rtl/wwb_pkg.sv
package wwb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_REL  = 3'd3
  } phase_t;

  localparam logic [1:0] AW_SEL_NARROW = 2'd0;
  localparam logic [1:0] AW_SEL_MID    = 2'd1;
endpackage

// File: rtl/wwb_seq.sv
module wwb_seq
  import wwb_pkg::*;
#(
  parameter int DATA_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic ph_addr,
  output logic ph_data,
  output logic ph_rel,
  output logic busy,
  output logic done
);
  localparam int CW = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_CYC - 1);

  phase_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  assign accept = start && (state_q == PH_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      PH_IDLE: if (start) state_d = PH_ADDR;
      PH_ADDR: begin
        state_d = PH_DATA;
        cnt_d   = '0;
      end
      PH_DATA: begin
        if (cnt_q == LAST) state_d = PH_REL;
        else cnt_d = cnt_q + 1'b1;
      end
      PH_REL: begin
        state_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign ph_addr = (state_q == PH_ADDR);
  assign ph_data = (state_q == PH_DATA);
  assign ph_rel  = (state_q == PH_REL);
  assign busy    = (state_q != PH_IDLE);
  assign done    = done_q;

  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_addr |=> ph_data); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ph_rel) |=> busy); // R9
endmodule

// File: rtl/wwb_hold.sv
module wwb_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] hold
);
  logic [BYTE_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (cap_en) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;

  AST_HOLD_ONLY_ON_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(hold_q)); // R10
endmodule

// File: rtl/wwb_addr.sv
module wwb_addr
  import wwb_pkg::*;
#(
  parameter int WA_W   = 20,
  parameter int BUS_W  = 16,
  parameter int NARROW = 12,
  parameter int MID    = 16
) (
  input  logic [1:0]          aw_sel,
  input  logic [WA_W-1:0]     word_addr,
  output logic [BUS_W-1:0]    addr_lo,
  output logic [WA_W-BUS_W-1:0] addr_hi
);
  logic [WA_W-1:0] masked;

  for (genvar i = 0; i < WA_W; i++) begin : g_mask
    logic keep;
    always_comb begin
      if (aw_sel == AW_SEL_NARROW)   keep = (i < NARROW);
      else if (aw_sel == AW_SEL_MID) keep = (i < MID);
      else                           keep = 1'b1;
    end
    assign masked[i] = word_addr[i] & keep;
  end

  assign addr_lo = masked[BUS_W-1:0];
  assign addr_hi = masked[WA_W-1:BUS_W];
endmodule

// File: rtl/word_write_bus_if.sv
module word_write_bus_if
  import wwb_pkg::*;
#(
  parameter int PTR_W    = 21,
  parameter int BYTE_W   = 8,
  parameter int DATA_CYC = 2,
  parameter int AW_NARROW = 12,
  parameter int AW_MID    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_aw,
  input  logic                   req_start,
  input  logic [PTR_W-1:0]       req_ptr,
  input  logic [BYTE_W-1:0]      req_data,
  output logic                   busy,
  output logic                   done,
  output logic [PTR_W-2-2*BYTE_W:0] ext_addr_hi,
  output logic [2*BYTE_W-1:0]    ext_ad_o,
  output logic                   ext_ad_oe,
  output logic                   ext_ale,
  output logic                   ext_ce_n,
  output logic                   ext_oe_n,
  output logic                   ext_wrh_n,
  output logic                   ext_wrl_n,
  output logic                   ext_ub_n,
  output logic                   ext_lb_n,
  output logic                   ext_ba0
);
  localparam int WA_W  = PTR_W - 1;
  localparam int BUS_W = 2 * BYTE_W;
  localparam int HI_W  = WA_W - BUS_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic accept, ph_addr, ph_data, ph_rel, active, odd_drive;

  wwb_seq #(.DATA_CYC(DATA_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (req_start),
    .accept (accept),
    .ph_addr(ph_addr),
    .ph_data(ph_data),
    .ph_rel (ph_rel),
    .busy   (busy),
    .done   (done)
  );

  // request capture, enabled on accept
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [1:0]        aw_q, aw_d;

  always_comb begin
    ptr_d  = ptr_q;
    data_d = data_q;
    aw_d   = aw_q;
    if (accept) begin
      ptr_d  = req_ptr;
      data_d = req_data;
      aw_d   = cfg_aw;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ptr_q  <= '0;
      data_q <= '0;
      aw_q   <= '0;
    end else begin
      ptr_q  <= ptr_d;
      data_q <= data_d;
      aw_q   <= aw_d;
    end
  end

  logic [BYTE_W-1:0] hold;
  wwb_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cap_en(accept && !req_ptr[0]),
    .din   (req_data),
    .hold  (hold)
  );

  logic [BUS_W-1:0] addr_lo;
  logic [HI_W-1:0]  addr_hi;
  wwb_addr #(.WA_W(WA_W), .BUS_W(BUS_W), .NARROW(AW_NARROW), .MID(AW_MID)) u_addr (
    .aw_sel   (aw_q),
    .word_addr(ptr_q[PTR_W-1:1]),
    .addr_lo  (addr_lo),
    .addr_hi  (addr_hi)
  );

  assign active    = ph_addr | ph_data | ph_rel;
  assign odd_drive = (ph_data | ph_rel) & ptr_q[0];

  always_comb begin
    if (ph_addr)        ext_ad_o = addr_lo;
    else if (odd_drive) ext_ad_o = {data_q, hold};
    else                ext_ad_o = '0;
  end

  assign ext_addr_hi = active ? addr_hi : '0;
  assign ext_ad_oe   = ph_addr | odd_drive;
  assign ext_ale     = ph_addr;
  assign ext_ce_n    = ~active;
  assign ext_oe_n    = 1'b1;
  assign ext_wrh_n   = ~(ph_data & ptr_q[0]);
  assign ext_wrl_n   = 1'b1;
  assign ext_ub_n    = ~active;
  assign ext_lb_n    = ~active;
  assign ext_ba0     = active & ptr_q[0];

  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_ale |=> !ext_ale); // R2
  AST_STROBE_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(ext_wrh_n) |=> !ext_wrh_n); // R5
  AST_STROBE_RELEASED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(ext_wrh_n) ##1 !ext_wrh_n) |=> ext_wrh_n); // R8
  AST_DATA_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ext_wrh_n) |-> (ext_ad_oe && !ext_ce_n)); // R8
  AST_NARROW_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_ale && aw_q == AW_SEL_NARROW) |-> (ext_ad_o[BUS_W-1:AW_NARROW] == '0)); // R3
endmodule

// File: tb/tb_word_write_bus_if.sv
`timescale 1ns/1ps
module tb_word_write_bus_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_aw = 2'd2;
  logic req_start = 1'b0;
  logic [20:0] req_ptr = '0;
  logic [7:0] req_data = '0;
  logic busy, done, ext_ad_oe, ext_ale, ext_ce_n, ext_oe_n, ext_wrh_n, ext_wrl_n;
  logic ext_ub_n, ext_lb_n, ext_ba0;
  logic [3:0] ext_addr_hi;
  logic [15:0] ext_ad_o;

  always #2.5 clk = ~clk;

  word_write_bus_if dut (
    .clk(clk), .rst_n(rst_n), .cfg_aw(cfg_aw), .req_start(req_start),
    .req_ptr(req_ptr), .req_data(req_data), .busy(busy), .done(done),
    .ext_addr_hi(ext_addr_hi), .ext_ad_o(ext_ad_o), .ext_ad_oe(ext_ad_oe),
    .ext_ale(ext_ale), .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n),
    .ext_wrh_n(ext_wrh_n), .ext_wrl_n(ext_wrl_n), .ext_ub_n(ext_ub_n),
    .ext_lb_n(ext_lb_n), .ext_ba0(ext_ba0)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] model_hold = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(input logic [20:0] p, input logic [1:0] aw);
    logic [19:0] wa = p[20:1];
    if (aw == 2'd0)      return wa & 20'h00FFF;
    else if (aw == 2'd1) return wa & 20'h0FFFF;
    else                 return wa;
  endfunction

  // pins that never change: wrl_n, oe_n
  task automatic chk_static(input string tag);
    chk({"R6 wrl_n ", tag}, ext_wrl_n, 1'b1);
    chk({"R6 oe_n ", tag}, ext_oe_n, 1'b1);
  endtask

  // one write; optional ignored start during the first data clock
  task automatic do_write(input logic [20:0] p, input logic [7:0] d, input logic [1:0] aw,
                          input bit poke);
    logic [19:0] ea = exp_addr(p, aw);
    logic [7:0] lo = model_hold;
    bit odd = p[0];
    @(negedge clk);
    req_ptr = p; req_data = d; cfg_aw = aw; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0; req_ptr = $urandom; req_data = $urandom; cfg_aw = $urandom;
    // address phase
    chk("R2 ale", ext_ale, 1'b1);
    chk("R2 ad_oe addr", ext_ad_oe, 1'b1);
    chk("R3 addr lo", ext_ad_o, ea[15:0]);
    chk("R3 addr hi", ext_addr_hi, ea[19:16]);
    chk("R8 ce_n addr", ext_ce_n, 1'b0);
    chk("R7 ub/lb addr", {ext_ub_n, ext_lb_n}, 2'b00);
    chk("R7 ba0", ext_ba0, odd);
    chk("R9 busy addr", busy, 1'b1);
    chk_static("addr");
    if (!odd) model_hold = d;
    for (int k = 0; k < 2; k++) begin
      if (k == 0 && poke) begin
        req_start = 1'b1; req_ptr = {$urandom, 1'b0}; req_data = ~model_hold;
      end
      @(negedge clk);
      req_start = 1'b0;
      chk("R2 ale low data", ext_ale, 1'b0);
      chk("R8 ce_n data", ext_ce_n, 1'b0);
      chk("R7 ub/lb data", {ext_ub_n, ext_lb_n}, 2'b00);
      chk("R3 addr hi data", ext_addr_hi, ea[19:16]);
      chk_static("data");
      if (odd) begin
        chk("R5 wrh_n low", ext_wrh_n, 1'b0);
        chk("R5 ad_oe", ext_ad_oe, 1'b1);
        chk("R5 R10 word", ext_ad_o, {d, lo});
      end else begin
        chk("R4 wrh_n high", ext_wrh_n, 1'b1);
        chk("R4 bus released", ext_ad_oe, 1'b0);
      end
      chk("R9 busy data", busy, 1'b1);
    end
    @(negedge clk);
    chk("R8 release wrh_n", ext_wrh_n, 1'b1);
    chk("R8 ce_n release", ext_ce_n, 1'b0);
    chk("R8 release drive", ext_ad_oe, odd);
    chk("R9 busy release", busy, 1'b1);
    chk("R9 done not yet", done, 1'b0);
    @(negedge clk);
    chk("R9 done", done, 1'b1);
    chk("R9 busy off", busy, 1'b0);
    chk("R8 ce_n idle", ext_ce_n, 1'b1);
    chk("R3 hi idle", ext_addr_hi, 4'h0);
    chk("R7 ba0 idle", ext_ba0, 1'b0);
    @(negedge clk);
    chk("R9 done pulse", done, 1'b0);
    chk("R9 ignored start", busy, 1'b0);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 ce_n", ext_ce_n, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done", done, 1'b0);
    chk("R1 ale/oe", {ext_ale, ext_ad_oe}, 2'b00);
    chk("R1 strobes", {ext_ce_n, ext_oe_n, ext_wrh_n, ext_wrl_n, ext_ub_n, ext_lb_n}, 6'h3F);
    // R10: lone odd after reset sees 0x00
    do_write(21'h000001, 8'hA5, 2'd2, 1'b0);
    // pair at the top address, 20-bit width
    do_write(21'h1FFFFE, 8'h34, 2'd2, 1'b0);
    do_write(21'h1FFFFF, 8'h12, 2'd2, 1'b0);
    // narrow widths
    do_write(21'h1ABCD4, 8'h77, 2'd0, 1'b0);
    do_write(21'h1ABCD5, 8'h88, 2'd1, 1'b0);
    do_write(21'h0F0F0F, 8'h99, 2'd3, 1'b0);
    // R9/R10: start during busy ignored, hold untouched
    do_write(21'h000010, 8'h5A, 2'd2, 1'b1);
    do_write(21'h000011, 8'hC3, 2'd2, 1'b1);
    for (int i = 0; i < 80; i++) begin
      logic [20:0] p = $urandom;
      if ($urandom_range(0, 1) == 1) begin
        p[0] = 1'b0;
        do_write(p, $urandom, $urandom, 1'b0);
        p[0] = 1'b1;
      end
      do_write(p, $urandom, $urandom, ($urandom_range(0, 3) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule